// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts processor activity for profiling software. It holds one free-running cycle counter and two event counters. Each event counter has an 8-bit selector that picks one line out of a vector of single-cycle event pulses supplied by the core. Software reaches the block through four word registers chosen by a 2-bit index: 0 is control, 1 is the cycle count, 2 is event count 0 and 3 is event count 1. Every counter can be loaded directly through its own register. When a counter wraps it raises a sticky overflow flag, and one combined interrupt line reports any flag whose enable bit is set.

The event counters have no individual on/off switch. Software parks one by selecting code 0x20, the external trace-output line. That line is never asserted, so the counter holds its value. The cycle counter has no selector and stops only when the global enable is cleared. With its divide bit set, it advances once every 64 clocks. A value read from the control register can be written straight back: this acknowledges every raised flag and leaves every setting as it was.

Top module: `perf_mon`

## Requirements
- R1: After reset all four registers read zero and `irq` is low.
- R2: The control register layout is: bit 0 global enable, bit 1 event-counter reset, bit 2 cycle-counter reset, bit 3 divide, bits 6:4 interrupt enables (event 0, event 1, cycle), bits 10:8 overflow flags (same order), bits 27:20 selector of event counter 0 and bits 19:12 selector of event counter 1. Bits 1, 2, 7, 11 and 31:28 always read zero.
- R3: While enabled, an event counter adds one on each clock edge at which the event line indexed by its selector is high. Codes at or above the number of event lines (64) count nothing.
- R4: With selector code 0x20 and event line 32 low, an event counter holds its value, whatever the other lines do.
- R5: With the enable set and divide clear, the cycle counter adds one on every clock edge.
- R6: With enable and divide set, the cycle counter adds one on every 64th edge. A cycle-counter reset also restarts the 64-cycle phase, so after the reset edge the first step lands on the 64th following edge.
- R7: Writing register 1, 2 or 3 loads that counter at the write edge, overriding any count in that cycle. Writing zero resets the counter.
- R8: Writing control with bit 1 set clears both event counters at the write edge and leaves the cycle counter counting. Bit 2 clears only the cycle counter.
- R9: A counter that steps from 0xFFFFFFFF wraps to 0 and sets its overflow flag at the same edge.
- R10: An overflow flag stays set until a control write carries 1 in its bit. A 0 in that bit leaves it alone. Writing back a value just read clears the raised flags and changes no other setting.
- R11: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set.
- R12: With the global enable clear, no counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe for the indexed register |
| regIdx | input | 2 | Register index: 0 control, 1 cycle, 2 count 0, 3 count 1 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of the indexed register |
| evtIn | input | 64 | Single-cycle event pulses, line n selected by code n |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Register writes, resets and counter loads take effect at the clock edge of the write. The bench drives each write at a falling edge and reads back at the next falling edge, so exactly one rising edge separates stimulus and check. Event pulses are applied one per cycle between falling edges, and the expected count is the number of applied cycles in which the selected line was high. Because the cycle counter also advances on each write edge, that edge is included when its expected value is predicted. Divided counts are sampled at 63 and at 64 edges after the phase restart, which pins the prescaler boundary to the exact cycle.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

  localparam int SEL_W       = 8;
  localparam int NUM_EVT_CNT = 2;
  localparam int NUM_FLAGS   = 3;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CYC  = 2'd1;
  localparam logic [1:0] IDX_EVT0 = 2'd2;
  localparam logic [1:0] IDX_EVT1 = 2'd3;

  localparam int EN_BIT   = 0;
  localparam int RSTE_BIT = 1;
  localparam int RSTC_BIT = 2;
  localparam int DIV_BIT  = 3;
  localparam int IEN_LSB  = 4;
  localparam int FLAG_LSB = 8;
  localparam int SEL1_LSB = 12;
  localparam int SEL0_LSB = 20;

  localparam logic [SEL_W-1:0] PARK_CODE = 8'h20;

  typedef struct packed {
    logic en;
    logic div;
    logic [SEL_W-1:0] sel0;
    logic [SEL_W-1:0] sel1;
  } pmCfg_t;

  typedef struct packed {
    logic clrEvt;
    logic clrCyc;
    logic ldCyc;
    logic ldEvt0;
    logic ldEvt1;
  } pmStrobe_t;

endpackage

// File: rtl/perf_mon_cnt.sv
module perf_mon_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam logic [W-1:0] TOP_VAL = '1;

  assign wrap = inc && !clr && !ld && (val == TOP_VAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    val <= '0;
    else if (clr) val <= '0;
    else if (ld)  val <= ldVal;
    else if (inc) val <= val + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (val == '0)) else $error("wrap did not land on zero"); // R9

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (ld && !clr) |=> (val == $past(ldVal))) else $error("load lost"); // R7

endmodule

// File: rtl/perf_mon_dp.sv
module perf_mon_dp
  import perf_mon_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NUM_EVENTS = 64,
  parameter int PRESCALE   = 64
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  pmCfg_t                               cfg,
  input  pmStrobe_t                            strb,
  input  logic [NUM_EVENTS-1:0]                evtIn,
  input  logic [CNT_W-1:0]                     ldVal,
  output logic [CNT_W-1:0]                     cycVal,
  output logic [NUM_EVT_CNT-1:0][CNT_W-1:0]    evtVal,
  output logic [NUM_FLAGS-1:0]                 wrapPulse
);
  localparam int CODE_SPAN = 1 << SEL_W;
  localparam int PRE_W     = $clog2(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [CODE_SPAN-1:0] evtWide;
  assign evtWide = CODE_SPAN'(evtIn);

  // cycle prescaler
  logic [PRE_W-1:0] presc;
  logic preTick, cycInc, cycWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                presc <= '0;
    else if (strb.clrCyc)     presc <= '0;
    else if (cfg.en && cfg.div)
      presc <= (presc == PRE_LAST) ? '0 : presc + 1'b1;
  end

  assign preTick = cfg.en && cfg.div && (presc == PRE_LAST);
  assign cycInc  = cfg.en && (!cfg.div || preTick);

  perf_mon_cnt #(.W(CNT_W)) uCyc (
    .clk(clk), .rstN(rstN), .inc(cycInc), .clr(strb.clrCyc),
    .ld(strb.ldCyc), .ldVal(ldVal), .val(cycVal), .wrap(cycWrap)
  );

  // event counters
  logic [SEL_W-1:0]       selArr [NUM_EVT_CNT];
  logic [NUM_EVT_CNT-1:0] evtLd;
  logic [NUM_EVT_CNT-1:0] evtWrap;

  assign selArr[0] = cfg.sel0;
  assign selArr[1] = cfg.sel1;
  assign evtLd     = {strb.ldEvt1, strb.ldEvt0};

  for (genvar g = 0; g < NUM_EVT_CNT; g++) begin : gEvt
    logic hit;
    assign hit = evtWide[selArr[g]];
    perf_mon_cnt #(.W(CNT_W)) uEvt (
      .clk(clk), .rstN(rstN), .inc(cfg.en && hit), .clr(strb.clrEvt),
      .ld(evtLd[g]), .ldVal(ldVal), .val(evtVal[g]), .wrap(evtWrap[g])
    );
  end

  assign wrapPulse = {cycWrap, evtWrap};

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.sel0 == PARK_CODE && !evtWide[PARK_CODE] && !strb.clrEvt && !strb.ldEvt0)
    |=> $stable(evtVal[0])) else $error("parked counter moved"); // R4

  AST_CYC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.en && !strb.clrCyc && !strb.ldCyc) |=> $stable(cycVal))
    else $error("cycle counter moved while disabled"); // R12

  AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.div && presc != PRE_LAST && !strb.clrCyc && !strb.ldCyc)
    |=> $stable(cycVal)) else $error("divided counter stepped early"); // R6

  AST_EVT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEvt |=> (evtVal[0] == '0 && evtVal[1] == '0))
    else $error("event reset ignored"); // R8

endmodule

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
  import perf_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [1:0]                        regIdx,
  input  logic [DATA_W-1:0]                 wrData,
  output logic [DATA_W-1:0]                 rdData,
  input  logic [CNT_W-1:0]                  cycVal,
  input  logic [NUM_EVT_CNT-1:0][CNT_W-1:0] evtVal,
  input  logic [NUM_FLAGS-1:0]              wrapPulse,
  output pmCfg_t                            cfg,
  output pmStrobe_t                         strb,
  output logic                              irq
);
  logic ctlWr;
  logic [NUM_FLAGS-1:0] ien, flags, flagClr;
  logic [DATA_W-1:0] ctlWord;
  logic unusedWrBits;

  assign ctlWr = wrEn && (regIdx == IDX_CTRL);

  always_comb begin
    strb        = '0;
    strb.clrEvt = ctlWr && wrData[RSTE_BIT];
    strb.clrCyc = ctlWr && wrData[RSTC_BIT];
    strb.ldCyc  = wrEn && (regIdx == IDX_CYC);
    strb.ldEvt0 = wrEn && (regIdx == IDX_EVT0);
    strb.ldEvt1 = wrEn && (regIdx == IDX_EVT1);
  end

  assign flagClr = ctlWr ? wrData[FLAG_LSB +: NUM_FLAGS] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg   <= '0;
      ien   <= '0;
      flags <= '0;
    end else begin
      if (ctlWr) begin
        cfg.en   <= wrData[EN_BIT];
        cfg.div  <= wrData[DIV_BIT];
        cfg.sel0 <= wrData[SEL0_LSB +: SEL_W];
        cfg.sel1 <= wrData[SEL1_LSB +: SEL_W];
        ien      <= wrData[IEN_LSB +: NUM_FLAGS];
      end
      flags <= (flags & ~flagClr) | wrapPulse;
    end
  end

  assign irq = |(flags & ien);

  always_comb begin
    ctlWord                          = '0;
    ctlWord[EN_BIT]                  = cfg.en;
    ctlWord[DIV_BIT]                 = cfg.div;
    ctlWord[IEN_LSB +: NUM_FLAGS]    = ien;
    ctlWord[FLAG_LSB +: NUM_FLAGS]   = flags;
    ctlWord[SEL0_LSB +: SEL_W]       = cfg.sel0;
    ctlWord[SEL1_LSB +: SEL_W]       = cfg.sel1;
  end

  always_comb begin
    case (regIdx)
      IDX_CTRL: rdData = ctlWord;
      IDX_CYC:  rdData = DATA_W'(cycVal);
      IDX_EVT0: rdData = DATA_W'(evtVal[0]);
      default:  rdData = DATA_W'(evtVal[1]);
    endcase
  end

  assign unusedWrBits = ^{wrData[DATA_W-1:SEL0_LSB+SEL_W], wrData[11], wrData[7]};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlagChk
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> $past(wrapPulse[i])) else $error("flag without wrap"); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !(ctlWr && wrData[FLAG_LSB+i])) |=> flags[i])
      else $error("flag dropped"); // R10

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (ctlWr && wrData[FLAG_LSB+i] && !wrapPulse[i]) |=> !flags[i])
      else $error("flag not cleared"); // R10
  end

endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int NUM_EVENTS = 64,
  parameter int PRESCALE   = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            regIdx,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_EVENTS-1:0] evtIn,
  output logic                  irq
);
  pmCfg_t    cfg;
  pmStrobe_t strb;
  logic [CNT_W-1:0]                  cycVal;
  logic [NUM_EVT_CNT-1:0][CNT_W-1:0] evtVal;
  logic [NUM_FLAGS-1:0]              wrapPulse;

  perf_mon_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regIdx(regIdx), .wrData(wrData),
    .rdData(rdData), .cycVal(cycVal), .evtVal(evtVal), .wrapPulse(wrapPulse),
    .cfg(cfg), .strb(strb), .irq(irq)
  );

  perf_mon_dp #(.CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS), .PRESCALE(PRESCALE)) uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .evtIn(evtIn),
    .ldVal(wrData[CNT_W-1:0]), .cycVal(cycVal), .evtVal(evtVal), .wrapPulse(wrapPulse)
  );

endmodule

// File: tb/tb_perf_mon.sv
module tb_perf_mon;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regIdx = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] evtIn = '0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  perf_mon dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regIdx(regIdx), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .irq(irq)
  );

  function automatic logic [31:0] mkCtl(bit en, bit rstE, bit rstC, bit div,
      logic [2:0] ien, logic [2:0] flg, logic [7:0] s0, logic [7:0] s1);
    return {4'h0, s0, s1, 1'b0, flg, 1'b0, ien, div, rstC, rstE, en};
  endfunction

  function automatic logic [63:0] pat(int s, int c);
    logic [31:0] hi, lo;
    hi = 32'(c) * 32'h9E3779B9 + 32'(s);
    lo = (32'(s) * 32'h85EBCA6B) ^ (32'(c + 1) * 32'hC2B2AE35);
    return {hi, lo};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; one rising edge applies it; returns at the next falling edge
  task automatic wr(logic [1:0] idx, logic [31:0] d);
    regIdx = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(logic [1:0] idx, logic [31:0] exp, string tag);
    regIdx = idx;
    #1;
    chk(rdData == exp, tag, rdData, exp);
  endtask

  task automatic irqChk(bit exp, string tag);
    #1;
    chk(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int e0, e1;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 4; r++) rdChk(2'(r), 32'h0, "R1 reset value");
    irqChk(1'b0, "R1 irq after reset");

    // R2 layout, write-only bits read zero, disabled block stays still (R12)
    wr(2'd0, mkCtl(0, 1, 1, 1, 3'b101, 3'b000, 8'hA5, 8'h3C) | 32'h8000_0880);
    rdChk(2'd0, mkCtl(0, 0, 0, 1, 3'b101, 3'b000, 8'hA5, 8'h3C), "R2 control readback");
    evtIn = '1;
    idle(10);
    evtIn = '0;
    rdChk(2'd1, 32'd0, "R12 cycle frozen when disabled");
    rdChk(2'd2, 32'd0, "R12 event 0 frozen when disabled");
    rdChk(2'd3, 32'd0, "R12 event 1 frozen when disabled");

    // R5 cycle counting every edge
    wr(2'd0, mkCtl(1, 0, 1, 0, 3'b000, 3'b000, 8'h00, 8'h01));
    idle(37);
    rdChk(2'd1, 32'd37, "R5 cycle count after 37 edges");
    // R12 disable: the write edge still counts once
    wr(2'd0, mkCtl(0, 0, 0, 0, 3'b000, 3'b000, 8'h00, 8'h01));
    idle(20);
    rdChk(2'd1, 32'd38, "R12 cycle stops on disable");

    // R3 sweep of every selector code on both counters
    for (int s = 0; s < 64; s++) begin
      wr(2'd0, mkCtl(1, 1, 0, 0, 3'b000, 3'b000, 8'(s), 8'(63 - s)));
      e0 = 0; e1 = 0;
      for (int c = 0; c < 10; c++) begin
        evtIn = pat(s, c);
        if (evtIn[s]) e0++;
        if (evtIn[63 - s]) e1++;
        @(negedge clk);
      end
      evtIn = '0;
      rdChk(2'd2, 32'(e0), $sformatf("R3 event 0 code %0d", s));
      rdChk(2'd3, 32'(e1), $sformatf("R3 event 1 code %0d", 63 - s));
    end

    // R3 codes beyond the event vector count nothing
    wr(2'd0, mkCtl(1, 1, 0, 0, 3'b000, 3'b000, 8'hC8, 8'h40));
    evtIn = '1;
    idle(8);
    evtIn = '0;
    rdChk(2'd2, 32'd0, "R3 code 0xC8 counts nothing");
    rdChk(2'd3, 32'd0, "R3 code 0x40 counts nothing");

    // R4 parking with code 0x20
    wr(2'd0, mkCtl(1, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'h21));
    wr(2'd2, 32'd1234);
    wr(2'd3, 32'd0);
    evtIn = ~(64'h1 << 32);
    idle(12);
    evtIn = '0;
    rdChk(2'd2, 32'd1234, "R4 parked counter holds");
    rdChk(2'd3, 32'd12, "R4 neighbour line still counts");

    // R7 direct loads
    wr(2'd1, 32'h0000_0100);
    rdChk(2'd1, 32'h0000_0100, "R7 cycle load");
    wr(2'd1, 32'h0);
    rdChk(2'd1, 32'h0, "R7 cycle write zero");
    wr(2'd3, 32'hDEAD_BEEF);
    rdChk(2'd3, 32'hDEAD_BEEF, "R7 event 1 load");
    wr(2'd3, 32'h0);
    rdChk(2'd3, 32'h0, "R7 event 1 write zero");

    // R8 shared resets
    wr(2'd2, 32'd50);
    wr(2'd3, 32'd60);
    wr(2'd1, 32'd1000);
    wr(2'd0, mkCtl(1, 1, 0, 0, 3'b000, 3'b000, 8'h05, 8'h06));
    rdChk(2'd2, 32'd0, "R8 event reset clears count 0");
    rdChk(2'd3, 32'd0, "R8 event reset clears count 1");
    rdChk(2'd1, 32'd1001, "R8 event reset spares cycle");
    wr(2'd2, 32'd77);
    wr(2'd0, mkCtl(1, 0, 1, 0, 3'b000, 3'b000, 8'h05, 8'h06));
    rdChk(2'd1, 32'd0, "R8 cycle reset clears cycle");
    rdChk(2'd2, 32'd77, "R8 cycle reset spares count 0");

    // R9 wrap of event counter 0, enables off
    wr(2'd2, 32'hFFFF_FFFE);
    evtIn = 64'h1 << 5;
    idle(2);
    evtIn = '0;
    rdChk(2'd2, 32'h0, "R9 event 0 wraps to zero");
    rdChk(2'd0, mkCtl(1, 0, 0, 0, 3'b000, 3'b001, 8'h05, 8'h06), "R9 flag 0 set");
    irqChk(1'b0, "R11 flag without enable");
    // R10/R11 enabling keeps the flag and raises irq
    wr(2'd0, mkCtl(1, 0, 0, 0, 3'b001, 3'b000, 8'h05, 8'h06));
    rdChk(2'd0, mkCtl(1, 0, 0, 0, 3'b001, 3'b001, 8'h05, 8'h06), "R10 zero in flag bit keeps it");
    irqChk(1'b1, "R11 flag with enable");
    // R9 event 1 and cycle wraps
    wr(2'd3, 32'hFFFF_FFFF);
    evtIn = 64'h1 << 6;
    @(negedge clk);
    evtIn = '0;
    rdChk(2'd3, 32'h0, "R9 event 1 wraps to zero");
    wr(2'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    rdChk(2'd1, 32'h0, "R9 cycle wraps to zero");
    rdChk(2'd0, mkCtl(1, 0, 0, 0, 3'b001, 3'b111, 8'h05, 8'h06), "R9 all three flags");

    // R10 read-modify-write
    regIdx = 2'd0; #1; v = rdData;
    @(negedge clk);
    wr(2'd0, v);
    rdChk(2'd0, mkCtl(1, 0, 0, 0, 3'b001, 3'b000, 8'h05, 8'h06), "R10 write-back clears flags only");
    rdChk(2'd2, 32'h0, "R10 write-back causes no reset");
    irqChk(1'b0, "R11 irq drops after clear");

    // R10/R11 selective clearing
    wr(2'd0, mkCtl(1, 0, 0, 0, 3'b011, 3'b000, 8'h05, 8'h06));
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    evtIn = (64'h1 << 5) | (64'h1 << 6);
    @(negedge clk);
    evtIn = '0;
    wr(2'd0, mkCtl(1, 0, 0, 0, 3'b011, 3'b010, 8'h05, 8'h06));
    rdChk(2'd0, mkCtl(1, 0, 0, 0, 3'b011, 3'b001, 8'h05, 8'h06), "R10 clear only flag 1");
    irqChk(1'b1, "R11 remaining flag keeps irq");
    wr(2'd0, mkCtl(1, 0, 0, 0, 3'b010, 3'b000, 8'h05, 8'h06));
    irqChk(1'b0, "R11 flag 0 masked off");
    wr(2'd0, mkCtl(1, 0, 0, 0, 3'b010, 3'b001, 8'h05, 8'h06));
    rdChk(2'd0, mkCtl(1, 0, 0, 0, 3'b010, 3'b000, 8'h05, 8'h06), "R10 clear flag 0");

    // R6 divided cycle counting
    wr(2'd0, mkCtl(1, 0, 1, 1, 3'b000, 3'b000, 8'h05, 8'h06));
    idle(63);
    rdChk(2'd1, 32'd0, "R6 no step before 64 edges");
    idle(1);
    rdChk(2'd1, 32'd1, "R6 step on 64th edge");
    idle(128);
    rdChk(2'd1, 32'd3, "R6 three steps after 192 edges");
    idle(63);
    rdChk(2'd1, 32'd3, "R6 hold within phase");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule